// File: doc/BRIEF.md
# Oversampled Manchester Line Receiver with Word Deframer

This block takes a Manchester-coded serial line and turns it back into bits and then into 16-bit words. It runs on a local clock of roughly eight times the line bit rate. The two ends may run at slightly different rates. Inside each bit cell, the edge at mid-cell carries the data. The level after that edge is the bit value. The edges at cell boundaries are only there to make room for the next mid-cell edge, and the receiver ignores them.

The input is asynchronous. It is synchronized first, and transitions are then detected on the synchronized samples. A phase counter restarts on every accepted mid-cell edge and ignores any transitions that fall in a blanking window after it. If the expected edge does not arrive within a time-out, the receiver raises a loss-of-lock pulse.

The decoded bit stream feeds a deframer. After a long enough run of zero bits, the deframer takes the next one bit as a start marker. It loads that marker at the head of a shift chain, and the data bits shift in behind it. When the marker falls out of the far end of the chain, all 16 data bits are in place. They are copied to the parallel word register, and a one-cycle valid pulse marks the update.

Top module: `manchester_rx`

## Requirements
- R1: While reset is active, and directly after it with the line held still, `bit_data`, `bit_strobe`, `word_data`, `word_valid` and `lock_lost` are all 0.
- R2: Each accepted mid-cell transition gives a one-cycle `bit_strobe`. The `bit_data` value is the line level after the transition, so a falling transition decodes as 0 and a rising one as 1. A steady stream gives exactly one strobe per bit cell.
- R3: For 6 clock cycles after an accepted transition, further transitions are ignored. Two strobes are therefore never less than 6 cycles apart, and a short glitch in the second half of a cell does not change the decoded bits.
- R4: Bit cells of 7, 8 and 9 clock cycles decode without error and without loss of lock.
- R5: If no transition is accepted within 12 cycles of the last one, `lock_lost` pulses for one cycle. Any partly received word is then discarded, and the deframer goes back to searching for a zero run. `lock_lost` and `bit_strobe` are never high together.
- R6: A one bit is taken as a start marker only after at least 18 consecutive decoded zero bits. After 17 zeros, the one bit is not a start, and the zero count starts again from 0.
- R7: The 16 bits that follow a start marker form the word. The first bit received goes to `word_data[15]` and the last to `word_data[0]`. The word loads when the marker leaves the end of the 16-stage chain, which is the cycle after the strobe of the 16th data bit.
- R8: `word_valid` is a one-cycle pulse, given at most once per frame. `word_data` changes only in the cycle where `word_valid` is high and holds its value otherwise.
- R9: After a word is loaded, a new run of at least 18 zero bits is needed before the next start marker is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, about eight times the bit rate |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| line_in | input | 1 | Raw Manchester line, asynchronous to `clk` |
| bit_data | output | 1 | Last decoded bit value |
| bit_strobe | output | 1 | One-cycle pulse per decoded bit |
| word_data | output | 16 | Last received word, first bit received in bit 15 |
| word_valid | output | 1 | One-cycle pulse when `word_data` is loaded |
| lock_lost | output | 1 | One-cycle pulse when the mid-cell time-out expires |

## Verification
The checker watches several properties on every cycle:
- the pulse shapes of `bit_strobe`, `word_valid` and `lock_lost`;
- the minimum spacing of strobes set by the blanking window;
- that `word_data` holds between loads;
- that a word loads only right after a bit strobe and after the marker reaches the end of the chain;
- that no frame starts without a full zero run.

Some behaviours can only be shown by the bench's scenarios:
- that bits decode to the right values at different cell lengths and with glitches present;
- that the bit order in the word is correct;
- that a run of 17 zeros is not enough and a run of 18 is;
- that a line that stalls part-way through a frame loses the word and then recovers.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef enum logic {
    FRM_HUNT  = 1'b0,
    FRM_SHIFT = 1'b1
  } frm_state_t;

  // Next value of the mid-cell phase counter.
  function automatic int unsigned phase_step(int unsigned ph, logic taken,
                                             int unsigned blank, int unsigned loss);
    if (taken) return 0;
    if (ph >= loss) return blank;
    return ph + 1;
  endfunction

  // Next length of the zero run seen while hunting, saturating at cap.
  function automatic int unsigned run_step(int unsigned run, logic bit_val,
                                           int unsigned cap);
    if (bit_val) return 0;
    if (run >= cap) return cap;
    return run + 1;
  endfunction

endpackage

// File: rtl/mrx_sync.sv
module mrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mrx_bit_decoder.sv
module mrx_bit_decoder #(
  parameter int BLANK_CYC = 6,
  parameter int LOSS_CYC  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  output logic bit_data,
  output logic bit_strobe,
  output logic lock_lost,
  output logic edge_taken
);
  localparam int CW = $clog2(LOSS_CYC + 1);

  logic          line_q;
  logic [CW-1:0] phase_q;
  logic          edge_seen;
  logic          armed;
  logic          timeout;

  assign edge_seen  = line_s ^ line_q;
  assign armed      = (phase_q >= CW'(BLANK_CYC));
  assign edge_taken = edge_seen & armed;
  assign timeout    = !edge_taken && (phase_q >= CW'(LOSS_CYC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q     <= 1'b0;
      phase_q    <= CW'(BLANK_CYC);
      bit_data   <= 1'b0;
      bit_strobe <= 1'b0;
      lock_lost  <= 1'b0;
    end else begin
      line_q     <= line_s;
      bit_strobe <= edge_taken;
      lock_lost  <= timeout;
      if (edge_taken) bit_data <= line_s;
      phase_q <= CW'(mrx_pkg::phase_step(32'(phase_q), edge_taken,
                                         BLANK_CYC, LOSS_CYC));
    end
  end
endmodule

// File: rtl/mrx_deframer.sv
module mrx_deframer #(
  parameter int DATA_W    = 16,
  parameter int MIN_ZEROS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_data,
  input  logic              bit_strobe,
  input  logic              lock_lost,
  output logic [DATA_W-1:0] word_data,
  output logic              word_valid,
  output logic              in_frame,
  output logic              marker_done
);
  import mrx_pkg::*;

  localparam int RW = $clog2(MIN_ZEROS + 1);

  frm_state_t      state_q;
  logic [RW-1:0]   run_q;
  logic [DATA_W:0] chain_q;
  logic [DATA_W:0] chain_nxt;
  logic            start_ok;

  assign chain_nxt   = {chain_q[DATA_W-1:0], bit_data};
  assign start_ok    = (state_q == FRM_HUNT) && bit_strobe && bit_data &&
                       (run_q >= RW'(MIN_ZEROS));
  assign marker_done = (state_q == FRM_SHIFT) && bit_strobe && chain_nxt[DATA_W];
  assign in_frame    = (state_q == FRM_SHIFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= FRM_HUNT;
      run_q      <= '0;
      chain_q    <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (lock_lost) begin
        state_q <= FRM_HUNT;
        run_q   <= '0;
        chain_q <= '0;
      end else if (bit_strobe) begin
        if (state_q == FRM_HUNT) begin
          if (start_ok) begin
            state_q <= FRM_SHIFT;
            run_q   <= '0;
            chain_q <= {{DATA_W{1'b0}}, 1'b1};
          end else begin
            run_q <= RW'(run_step(32'(run_q), bit_data, MIN_ZEROS));
          end
        end else if (marker_done) begin
          word_data  <= chain_nxt[DATA_W-1:0];
          word_valid <= 1'b1;
          state_q    <= FRM_HUNT;
          run_q      <= '0;
          chain_q    <= '0;
        end else begin
          chain_q <= chain_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int DATA_W      = 16,
  parameter int BLANK_CYC   = 6,
  parameter int LOSS_CYC    = 12,
  parameter int MIN_ZEROS   = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  output logic              bit_data,
  output logic              bit_strobe,
  output logic [DATA_W-1:0] word_data,
  output logic              word_valid,
  output logic              lock_lost
);
  logic line_s;
  logic dec_edge_taken;
  logic frm_busy;
  logic frm_marker_done;

  mrx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_in),
    .q     (line_s)
  );

  mrx_bit_decoder #(.BLANK_CYC(BLANK_CYC), .LOSS_CYC(LOSS_CYC)) i_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_s     (line_s),
    .bit_data   (bit_data),
    .bit_strobe (bit_strobe),
    .lock_lost  (lock_lost),
    .edge_taken (dec_edge_taken)
  );

  mrx_deframer #(.DATA_W(DATA_W), .MIN_ZEROS(MIN_ZEROS)) i_frm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_data    (bit_data),
    .bit_strobe  (bit_strobe),
    .lock_lost   (lock_lost),
    .word_data   (word_data),
    .word_valid  (word_valid),
    .in_frame    (frm_busy),
    .marker_done (frm_marker_done)
  );
endmodule

// File: rtl/mrx_checker.sv
module mrx_checker #(
  parameter int DATA_W    = 16,
  parameter int BLANK_CYC = 6,
  parameter int MIN_ZEROS = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_data,
  input logic              bit_strobe,
  input logic [DATA_W-1:0] word_data,
  input logic              word_valid,
  input logic              lock_lost,
  input logic              edge_taken,
  input logic              in_frame,
  input logic              marker_done
);
  localparam int GW = $clog2(BLANK_CYC + 1) + 1;
  localparam int ZW = $clog2(MIN_ZEROS + 1) + 1;

  logic [GW-1:0] gap_q;
  logic [ZW-1:0] zrun_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= GW'(BLANK_CYC);
      zrun_q <= '0;
    end else begin
      if (bit_strobe)                   gap_q <= GW'(1);
      else if (gap_q < GW'(BLANK_CYC))  gap_q <= gap_q + GW'(1);
      if (lock_lost || in_frame || (bit_strobe && bit_data)) zrun_q <= '0;
      else if (bit_strobe && zrun_q < ZW'(MIN_ZEROS))        zrun_q <= zrun_q + ZW'(1);
    end
  end

  // R2
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  // R2
  strobe_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_taken |=> bit_strobe);

  // R3
  blank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> gap_q >= GW'(BLANK_CYC));

  // R5
  lost_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |-> !bit_strobe);

  // R5
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> !lock_lost);

  // R5
  lost_drops_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_lost |=> !in_frame);

  // R6
  start_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && bit_data && !in_frame && zrun_q < ZW'(MIN_ZEROS)) |=> !in_frame);

  // R7
  load_after_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
    marker_done |=> word_valid);

  // R7
  load_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(bit_strobe));

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data));
endmodule

bind manchester_rx mrx_checker #(
  .DATA_W(DATA_W), .BLANK_CYC(BLANK_CYC), .MIN_ZEROS(MIN_ZEROS)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_data    (bit_data),
  .bit_strobe  (bit_strobe),
  .word_data   (word_data),
  .word_valid  (word_valid),
  .lock_lost   (lock_lost),
  .edge_taken  (dec_edge_taken),
  .in_frame    (frm_busy),
  .marker_done (frm_marker_done)
);

// File: tb/test_manchester_rx.sv
module test_manchester_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_in = 1'b0;
  logic        bit_data;
  logic        bit_strobe;
  logic [15:0] word_data;
  logic        word_valid;
  logic        lock_lost;

  always #2 clk = ~clk;

  manchester_rx i_manchester_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .bit_data   (bit_data),
    .bit_strobe (bit_strobe),
    .word_data  (word_data),
    .word_valid (word_valid),
    .lock_lost  (lock_lost)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int n_strobe = 0;
  int n_words  = 0;
  int n_lost   = 0;
  logic [15:0] mon_bits  = '0;
  logic [15:0] last_bits = '0;
  logic [15:0] last_word = '0;
  bit done = 0;

  // Monitor: the bench's own record of decoded bits and events
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_strobe) begin
        n_strobe = n_strobe + 1;
        mon_bits = {mon_bits[14:0], bit_data};
      end
      if (word_valid) begin
        n_words   = n_words + 1;
        last_word = word_data;
        last_bits = mon_bits;
      end
      if (lock_lost) n_lost = n_lost + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One Manchester cell: first part ~d, second part d (optional short glitch)
  task automatic send_bit(input logic d, input int ha, input int hb, input bit gl);
    for (int i = 0; i < ha; i++) begin
      @(negedge clk); line_in = ~d;
    end
    for (int i = 0; i < hb; i++) begin
      @(negedge clk); line_in = (gl && i == 1) ? ~d : d;
    end
  endtask

  task automatic send_frame(input logic [15:0] w, input int ha, input int hb,
                            input bit gl, input int nz);
    send_bit(1'b1, ha, hb, gl);
    for (int i = 0; i < nz; i++) send_bit(1'b0, ha, hb, gl);
    send_bit(1'b1, ha, hb, gl);
    for (int i = 15; i >= 0; i--) send_bit(w[i], ha, hb, gl);
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); #1;
  endtask

  // {word, first-half cycles, second-half cycles, glitch}
  localparam logic [24:0] VEC [8] = '{
    {16'hA5C3, 4'd4, 4'd4, 1'b0},
    {16'hFFFF, 4'd4, 4'd4, 1'b0},
    {16'h0000, 4'd4, 4'd4, 1'b0},
    {16'h8001, 4'd5, 4'd4, 1'b0},
    {16'h7FFE, 4'd4, 4'd3, 1'b0},
    {16'h3C96, 4'd4, 4'd4, 1'b1},
    {16'h1234, 4'd3, 4'd4, 1'b0},
    {16'hC001, 4'd5, 4'd4, 1'b1}
  };

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, w0, l0;
    repeat (4) @(posedge clk);
    #1;
    // R1: outputs quiet while in reset
    check(word_valid == 0 && bit_strobe == 0 && lock_lost == 0 && word_data == 0,
          "R1 in reset", {word_valid, bit_strobe, lock_lost, word_data}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    // R1: outputs quiet just after reset with a still line
    check(word_valid == 0 && bit_strobe == 0 && bit_data == 0 && word_data == 0 &&
          lock_lost == 0, "R1 after reset",
          {word_valid, bit_strobe, bit_data, lock_lost, word_data}, 0);

    // R5: still line gives loss-of-lock pulses
    repeat (20) @(posedge clk);
    #1;
    check(n_lost > 0, "R5 idle line", n_lost, 1);

    // Warm-up to bring the cell phase in line
    send_bit(1'b1, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    send_bit(1'b1, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    settle();

    // Table of frames: R2 R3 R4 R7 R8
    for (int v = 0; v < 8; v++) begin
      logic [15:0] w;
      int ha, hb;
      bit gl;
      w  = VEC[v][24:9];
      ha = int'(VEC[v][8:5]);
      hb = int'(VEC[v][4:1]);
      gl = VEC[v][0];
      s0 = n_strobe; w0 = n_words; l0 = n_lost;
      send_frame(w, ha, hb, gl, 20);
      send_bit(1'b0, ha, hb, gl); send_bit(1'b0, ha, hb, gl);
      settle();
      check(n_words - w0 == 1, "R8 one word per frame", n_words - w0, 1);
      check(last_word == w, "R7 word bits", last_word, w);
      check(last_bits == w, "R2 decoded bit values", last_bits, w);
      check(n_strobe - s0 == 40, gl ? "R3 strobes with glitches" : "R2 strobe per cell",
            n_strobe - s0, 40);
      check(n_lost == l0, "R4 no loss at this cell length", n_lost - l0, 0);
    end

    // R6: 17 zeros are not enough
    w0 = n_words;
    send_frame(16'hFFFF, 4, 4, 0, 17);
    send_bit(1'b0, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    settle();
    check(n_words == w0, "R6 17 zeros rejected", n_words - w0, 0);

    // R6: exactly 18 zeros are enough
    w0 = n_words;
    send_frame(16'h5A5A, 4, 4, 0, 18);
    send_bit(1'b0, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    settle();
    check(n_words - w0 == 1 && last_word == 16'h5A5A, "R6 18 zeros accepted",
          last_word, 16'h5A5A);

    // R9: short run after a loaded word does not start a frame
    w0 = n_words;
    for (int i = 0; i < 5; i++) send_bit(1'b0, 4, 4, 0);
    send_bit(1'b1, 4, 4, 0);
    for (int i = 0; i < 16; i++) send_bit(1'b1, 4, 4, 0);
    send_bit(1'b0, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    settle();
    check(n_words == w0, "R9 new run needed", n_words - w0, 0);
    check(last_word == 16'h5A5A && word_data == 16'h5A5A, "R8 word held",
          word_data, 16'h5A5A);

    // R5: line stalls in the middle of a frame
    w0 = n_words; l0 = n_lost;
    send_bit(1'b1, 4, 4, 0);
    for (int i = 0; i < 20; i++) send_bit(1'b0, 4, 4, 0);
    send_bit(1'b1, 4, 4, 0);
    for (int i = 0; i < 8; i++) send_bit(1'b0, 4, 4, 0);
    repeat (20) @(negedge clk);
    check(n_lost > l0, "R5 stall flagged", n_lost - l0, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 4, 4, 0);
    send_bit(1'b0, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    settle();
    check(n_words == w0, "R5 partial word dropped", n_words - w0, 0);

    // R5: recovery with a full frame
    w0 = n_words;
    send_frame(16'h0F0F, 4, 4, 0, 20);
    send_bit(1'b0, 4, 4, 0); send_bit(1'b0, 4, 4, 0);
    settle();
    check(n_words - w0 == 1 && last_word == 16'h0F0F, "R5 recovery", last_word, 16'h0F0F);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule